// File: doc/BRIEF.md
# Measurement Cycle Timer

This block paces a ranging instrument. It divides a 5 MHz reference clock into a repeating measurement cycle whose rate software picks from four settings. Each cycle opens with a one-clock time-zero strobe. A cycle-reset window sits a fixed number of clocks after time zero, so it always lands before the laser is fired. A CPU interrupt pulse of fixed width starts with each cycle. A coarse timestamp counter, in units of one reference period (200 ns), restarts at every cycle boundary.

When enabled, the external one-pulse-per-second timing input re-phases the cycle: its rising edge, after a two-flop synchroniser, restarts the cycle at once. When the enable is off, or when no pulse arrives, the timer free-runs at the selected rate. The block also drives the reset line of the time-of-flight units. It raises a sticky cycle-slip flag when a cycle begins before the CPU has serviced the previous interrupt.

Top module: `cyc_timer`

## Requirements
- R1: Rate code `rate_sel` 2'b00, 2'b01, 2'b10 and 2'b11 select cycle periods of P1HZ, P6HZ, P8HZ and P10HZ clocks (defaults 5,000,000 / 833,333 / 625,000 / 500,000). `tz_o` pulses for one clock once per period.
- R2: While `rst_n` is low, `tz_o`, `irq_o`, `cycle_rst_o`, `slip_o` and `coarse_o` are 0 and `tof_rst_o` is 1.
- R3: With `pps_en` = 0, edges on `pps_in` do not move the cycle boundary.
- R4: With `pps_en` = 1, a rising edge of `pps_in` first seen at clock edge k puts `tz_o` high after clock edge k+2, and the cycle restarts from index 0.
- R5: With `pps_en` = 1 and no edge on `pps_in`, the timer keeps its selected period with no stall.
- R6: `irq_o` rises together with `tz_o` and stays high for exactly IRQ_W clocks (default 32, i.e. 6.4 µs).
- R7: `coarse_o` is 0 in the time-zero clock and rises by 1 per clock. It holds at its all-ones value instead of wrapping.
- R8: `cycle_rst_o` is high for cycle indices CRST_AT to CRST_AT+CRST_W-1, counted with time zero as index 0.
- R9: `tof_rst_o` is high during hardware reset and during `sw_rst`. It also follows `cycle_rst_o`, but only when `cr_en_hi` and `cr_en_lo` are both 1.
- R10: If a cycle starts while the previous interrupt is still unacknowledged (no `irq_ack` since the prior start), `slip_o` goes to 1 in the same clock as `tz_o`.
- R11: `slip_o` stays 1 until a `stat_rd` pulse, and `irq_ack` does not clear it. The clear takes effect at the clock edge that samples `stat_rd`.
- R12: When `irq_ack` is given within every cycle, `slip_o` stays 0.
- R13: A `sw_rst` pulse restarts the timer exactly as hardware reset does. The next `tz_o` comes a full period after `sw_rst` is released.
- R14: If the rate changes to a period shorter than the current index, the cycle wraps on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 5 MHz reference clock |
| rst_n | input | 1 | Hardware power-on reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| rate_sel | input | 2 | Cycle rate code |
| pps_en | input | 1 | Enables phase alignment to `pps_in` |
| pps_in | input | 1 | External 1 Hz timing pulse, asynchronous |
| cr_en_hi | input | 1 | Cycle-reset-to-TOF enable, first bit |
| cr_en_lo | input | 1 | Cycle-reset-to-TOF enable, second bit |
| irq_ack | input | 1 | CPU has serviced the interrupt |
| stat_rd | input | 1 | Status word read strobe, clears the slip flag |
| tz_o | output | 1 | Time-zero strobe, one clock per cycle |
| cycle_rst_o | output | 1 | Cycle-reset window |
| irq_o | output | 1 | CPU interrupt pulse |
| coarse_o | output | COARSE_W | Coarse time within the cycle |
| tof_rst_o | output | 1 | Reset to the time-of-flight units |
| slip_o | output | 1 | Cycle-slip status flag (1 = slip) |

## Verification
The bench times each rate setting from one time-zero strobe to the next. A design that swapped two rate codes, or was off by one in its terminal count, would show the wrong period. Within the same period it checks the coarse counter at the saturation edge (it would wrap to zero if built wrongly), the interrupt width, and where the cycle-reset window falls. It measures the exact latency of a one-pulse-per-second edge, checks that the edge is ignored when disabled, and shows that a rate change to a shorter period wraps at once rather than running past the terminal count. The slip flag is driven through set, sticky hold against acknowledge, clear by read, and clearing by software reset, and the time-of-flight reset is checked with both enable bits and with only one.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

  typedef enum logic [1:0] {
    RATE_1HZ  = 2'b00,
    RATE_6HZ  = 2'b01,
    RATE_8HZ  = 2'b10,
    RATE_10HZ = 2'b11
  } rate_e;

  // Period in reference clocks for a rate code.
  function automatic logic [31:0] period_of(input logic [1:0] sel,
                                            input logic [31:0] p1,
                                            input logic [31:0] p6,
                                            input logic [31:0] p8,
                                            input logic [31:0] p10);
    case (rate_e'(sel))
      RATE_1HZ: period_of = p1;
      RATE_6HZ: period_of = p6;
      RATE_8HZ: period_of = p8;
      default:  period_of = p10;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Interrupt-slip decision for one cycle start.
  function automatic logic slip_event(input logic start, input logic pending,
                                      input logic ack);
    return start && pending && !ack;
  endfunction

endpackage

// File: rtl/cyc_period_gen.sv
module cyc_period_gen
  import cyc_timer_pkg::*;
#(
  parameter int unsigned P1HZ  = 5000000,
  parameter int unsigned P6HZ  = 833333,
  parameter int unsigned P8HZ  = 625000,
  parameter int unsigned P10HZ = 500000,
  parameter int unsigned CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic [1:0]       rate_sel,
  input  logic             pps_en,
  input  logic             pps_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o,
  output logic             tz_o,
  output logic             pps_hit_o
);

  logic [2:0]       pps_sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tz_q;
  logic [31:0]      cur_period;
  logic             wrap;
  logic             pps_edge;

  // Two synchroniser flops plus one history flop for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pps_sync_q <= '0;
    else        pps_sync_q <= {pps_sync_q[1:0], pps_in};
  end

  assign pps_edge   = pps_sync_q[1] && !pps_sync_q[2];
  assign pps_hit_o  = pps_en && pps_edge;
  assign cur_period = period_of(rate_sel, P1HZ, P6HZ, P8HZ, P10HZ);
  assign wrap       = (32'(cnt_q) + 32'd1) >= cur_period;
  assign start_o    = wrap || pps_hit_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tz_q  <= 1'b0;
    end else if (sw_rst) begin
      cnt_q <= '0;
      tz_q  <= 1'b0;
    end else begin
      cnt_q <= start_o ? '0 : cnt_q + 1'b1;
      tz_q  <= start_o;
    end
  end

  assign cnt_o = cnt_q;
  assign tz_o  = tz_q;

  // R4
  pps_restart_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    pps_hit_o |=> (cnt_q == '0) && tz_q);

  // R3
  pps_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (!pps_en && !wrap) |=> (cnt_q != '0) && !tz_q);

  // R14
  wrap_next_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    ((32'(cnt_q) + 32'd1) > cur_period) |=> tz_q);

endmodule

// File: rtl/cyc_pulse_gen.sv
module cyc_pulse_gen #(
  parameter int unsigned CNT_W   = 23,
  parameter int unsigned IRQ_W   = 32,
  parameter int unsigned CRST_AT = 8,
  parameter int unsigned CRST_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             start_i,
  input  logic             tz_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             irq_o,
  output logic             crst_o
);

  localparam int unsigned IRQ_CW   = $clog2(IRQ_W + 1);
  localparam int unsigned CRST_END = CRST_AT + CRST_W;

  logic [IRQ_CW-1:0] irq_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 irq_left_q <= '0;
    else if (sw_rst)            irq_left_q <= '0;
    else if (start_i)           irq_left_q <= IRQ_CW'(IRQ_W);
    else if (irq_left_q != '0)  irq_left_q <= irq_left_q - 1'b1;
  end

  assign irq_o  = (irq_left_q != '0);
  assign crst_o = (32'(cnt_i) >= CRST_AT) && (32'(cnt_i) < CRST_END);

  // R6
  irq_start_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    $rose(irq_o) |-> tz_i);

  // R6
  irq_at_tz_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    tz_i |-> irq_o);

  // R8
  crst_clear_of_tz_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    crst_o |-> !tz_i);

endmodule

// File: rtl/cyc_slip_tof.sv
module cyc_slip_tof
  import cyc_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic start_i,
  input  logic ack_i,
  input  logic stat_rd_i,
  input  logic crst_i,
  input  logic en_hi_i,
  input  logic en_lo_i,
  output logic slip_o,
  output logic tof_rst_o
);

  logic pending_q;
  logic slip_q;
  logic slip_set;

  assign slip_set = slip_event(start_i, pending_q, ack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      slip_q    <= 1'b0;
    end else if (sw_rst) begin
      pending_q <= 1'b0;
      slip_q    <= 1'b0;
    end else begin
      if (start_i)    pending_q <= 1'b1;
      else if (ack_i) pending_q <= 1'b0;
      if (slip_set)       slip_q <= 1'b1;
      else if (stat_rd_i) slip_q <= 1'b0;
    end
  end

  assign slip_o    = slip_q;
  assign tof_rst_o = !rst_n || sw_rst || (crst_i && en_hi_i && en_lo_i);

  // R10
  slip_set_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (start_i && pending_q && !ack_i) |=> slip_q);

  // R11
  slip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (slip_q && !stat_rd_i) |=> slip_q);

  // R9
  tof_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (crst_i && !(en_hi_i && en_lo_i)) |-> !tof_rst_o);

endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
  import cyc_timer_pkg::*;
#(
  parameter int unsigned P1HZ     = 5000000,
  parameter int unsigned P6HZ     = 833333,
  parameter int unsigned P8HZ     = 625000,
  parameter int unsigned P10HZ    = 500000,
  parameter int unsigned IRQ_W    = 32,
  parameter int unsigned CRST_AT  = 8,
  parameter int unsigned CRST_W   = 4,
  parameter int unsigned COARSE_W = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_rst,
  input  logic [1:0]          rate_sel,
  input  logic                pps_en,
  input  logic                pps_in,
  input  logic                cr_en_hi,
  input  logic                cr_en_lo,
  input  logic                irq_ack,
  input  logic                stat_rd,
  output logic                tz_o,
  output logic                cycle_rst_o,
  output logic                irq_o,
  output logic [COARSE_W-1:0] coarse_o,
  output logic                tof_rst_o,
  output logic                slip_o
);

  localparam int unsigned PMAX  = max4(P1HZ, P6HZ, P8HZ, P10HZ);
  localparam int unsigned CNT_W = $clog2(PMAX);

  logic [CNT_W-1:0]    cnt;
  logic                start;
  logic                pps_hit;
  logic [COARSE_W-1:0] coarse_q;
  logic                coarse_full;

  cyc_period_gen #(
    .P1HZ(P1HZ), .P6HZ(P6HZ), .P8HZ(P8HZ), .P10HZ(P10HZ), .CNT_W(CNT_W)
  ) u_period (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rate_sel(rate_sel),
    .pps_en(pps_en), .pps_in(pps_in), .cnt_o(cnt), .start_o(start),
    .tz_o(tz_o), .pps_hit_o(pps_hit)
  );

  cyc_pulse_gen #(
    .CNT_W(CNT_W), .IRQ_W(IRQ_W), .CRST_AT(CRST_AT), .CRST_W(CRST_W)
  ) u_pulse (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .start_i(start), .tz_i(tz_o),
    .cnt_i(cnt), .irq_o(irq_o), .crst_o(cycle_rst_o)
  );

  cyc_slip_tof u_slip (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .start_i(start),
    .ack_i(irq_ack), .stat_rd_i(stat_rd), .crst_i(cycle_rst_o),
    .en_hi_i(cr_en_hi), .en_lo_i(cr_en_lo), .slip_o(slip_o),
    .tof_rst_o(tof_rst_o)
  );

  // Coarse time: one count per reference clock, held at full scale.
  assign coarse_full = &coarse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            coarse_q <= '0;
    else if (sw_rst)       coarse_q <= '0;
    else if (start)        coarse_q <= '0;
    else if (!coarse_full) coarse_q <= coarse_q + 1'b1;
  end

  assign coarse_o = coarse_q;

  // R7
  coarse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    tz_o |-> (coarse_o == '0));

  // R7
  coarse_sat_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (coarse_full && !start) |=> coarse_full);

  // R4
  pps_tz_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    pps_hit |=> tz_o);

endmodule

// File: tb/cyc_timer_test.sv
module cyc_timer_test;

  localparam int unsigned CW     = 5;
  localparam int unsigned CMAX   = (1 << CW) - 1;
  localparam int unsigned IRQW   = 4;
  localparam int unsigned CRA    = 3;
  localparam int unsigned CRW    = 2;
  localparam int          NVEC   = 4;
  localparam int          VRATE [NVEC] = '{0, 1, 2, 3};
  localparam int          VPER  [NVEC] = '{60, 30, 24, 20};

  logic clk = 1'b0;
  logic rst_n = 1'b0, sw_rst = 1'b0, pps_en = 1'b0, pps_in = 1'b0;
  logic cr_en_hi = 1'b0, cr_en_lo = 1'b0, irq_ack = 1'b1, stat_rd = 1'b0;
  logic [1:0] rate_sel = 2'b11;
  logic tz_o, cycle_rst_o, irq_o, tof_rst_o, slip_o;
  logic [CW-1:0] coarse_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cyc_timer #(
    .P1HZ(60), .P6HZ(30), .P8HZ(24), .P10HZ(20),
    .IRQ_W(IRQW), .CRST_AT(CRA), .CRST_W(CRW), .COARSE_W(CW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rate_sel(rate_sel),
    .pps_en(pps_en), .pps_in(pps_in), .cr_en_hi(cr_en_hi), .cr_en_lo(cr_en_lo),
    .irq_ack(irq_ack), .stat_rd(stat_rd), .tz_o(tz_o), .cycle_rst_o(cycle_rst_o),
    .irq_o(irq_o), .coarse_o(coarse_o), .tof_rst_o(tof_rst_o), .slip_o(slip_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Negedges until tz_o is seen high.
  task automatic to_tz(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tz_o && n < 1000);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    int e_irq, e_crst, e_crs;
    int exp_c;
    wait_n(3);
    // R2 reset state
    check(!tz_o && !irq_o && !cycle_rst_o && !slip_o, "R2 outputs idle", int'(irq_o), 0);
    check(coarse_o == 0, "R2 coarse", int'(coarse_o), 0);
    check(tof_rst_o, "R9 tof in hw reset", int'(tof_rst_o), 1);
    rst_n = 1'b1;

    // Vector table: period, irq width, cycle-reset window, coarse count.
    for (int v = 0; v < NVEC; v++) begin
      rate_sel = 2'(VRATE[v]);
      to_tz(n);
      e_irq = 0; e_crst = 0; e_crs = 0;
      n = 0;
      do begin
        exp_c = (n > int'(CMAX)) ? int'(CMAX) : n;
        if (irq_o != (n < int'(IRQW))) e_irq++;
        if (cycle_rst_o != (n >= int'(CRA) && n < int'(CRA + CRW))) e_crst++;
        if (int'(coarse_o) != exp_c) e_crs++;
        @(negedge clk);
        n++;
      end while (!tz_o && n < 1000);
      check(n == VPER[v], "R1 period", n, VPER[v]);
      check(e_irq == 0, "R6 irq width", e_irq, 0);
      check(e_crst == 0, "R8 cycle reset window", e_crst, 0);
      check(e_crs == 0, "R7 coarse count/saturate", e_crs, 0);
    end

    // R14 rate shortened past current index: wrap next clock
    rate_sel = 2'b00;
    to_tz(n);
    wait_n(40);
    rate_sel = 2'b11;
    to_tz(n);
    check(n == 1, "R14 wrap latency", n, 1);

    // R3 pps ignored when disabled
    to_tz(n);
    wait_n(5);
    pps_in = 1'b1;
    wait_n(4);
    pps_in = 1'b0;
    to_tz(n);
    check(n == 11, "R3 pps ignored", n, 11);

    // R4 pps edge restarts cycle
    pps_en = 1'b1;
    to_tz(n);
    wait_n(5);
    pps_in = 1'b1;
    to_tz(n);
    check(n == 3, "R4 pps latency", n, 3);
    check(coarse_o == 0, "R4 coarse restart", int'(coarse_o), 0);
    pps_in = 1'b0;
    // R5 free-run with enable and no pulse
    to_tz(n);
    check(n == 20, "R5 free run", n, 20);
    to_tz(n);
    check(n == 20, "R5 free run again", n, 20);
    pps_en = 1'b0;

    // R9 tof reset gating by both enable bits
    cr_en_hi = 1'b1; cr_en_lo = 1'b1;
    to_tz(n);
    wait_n(CRA);
    check(tof_rst_o, "R9 tof with both bits", int'(tof_rst_o), 1);
    wait_n(CRW);
    check(!tof_rst_o, "R9 tof after window", int'(tof_rst_o), 0);
    cr_en_lo = 1'b0;
    to_tz(n);
    wait_n(CRA);
    check(cycle_rst_o && !tof_rst_o, "R9 tof with one bit", int'(tof_rst_o), 0);

    // R10 slip on unacknowledged interrupt
    irq_ack = 1'b0;
    to_tz(n);
    check(!slip_o, "R10 no slip yet", int'(slip_o), 0);
    to_tz(n);
    check(slip_o, "R10 slip set", int'(slip_o), 1);
    // R11 sticky against ack, cleared by read
    wait_n(2);
    irq_ack = 1'b1;
    wait_n(1);
    irq_ack = 1'b0;
    wait_n(1);
    check(slip_o, "R11 slip sticky", int'(slip_o), 1);
    stat_rd = 1'b1;
    wait_n(1);
    stat_rd = 1'b0;
    check(!slip_o, "R11 slip cleared", int'(slip_o), 0);

    // R12 timely ack keeps slip low
    for (int c = 0; c < 3; c++) begin
      to_tz(n);
      irq_ack = 1'b1;
      wait_n(1);
      irq_ack = 1'b0;
    end
    check(!slip_o, "R12 no slip with ack", int'(slip_o), 0);

    // R13 software reset
    to_tz(n);
    to_tz(n);
    check(slip_o, "R13 slip set before sw reset", int'(slip_o), 1);
    wait_n(5);
    sw_rst = 1'b1;
    wait_n(1);
    check(coarse_o == 0 && !irq_o && !slip_o && !tz_o, "R13 state cleared", int'(coarse_o), 0);
    check(tof_rst_o, "R9 tof in sw reset", int'(tof_rst_o), 1);
    sw_rst = 1'b0;
    irq_ack = 1'b1;
    to_tz(n);
    check(n == 20, "R13 restart period", n, 20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule